// File: doc/BRIEF.md
# ECC-Protected Instruction Buffer with Fault Injection

This block is a small random-access store for 64-bit instruction words. Every entry carries a 32-bit instruction index and a 3-bit word index alongside the data. When protection is on, a single-error-correcting, double-error-detecting code is generated at write time and checked at read time. A single flipped bit is repaired before the word leaves the block. A double flip is reported, and the word is returned as stored.

For debug, a 2-bit fault control corrupts the data of the word being written, so that the checker can be exercised without real memory faults. Detected errors set two sticky status bits, one for correctable events and one for uncorrectable events. These bits are cleared by writing 1. Each bit drives the interrupt line only when its enable bit is set. The indices of the first faulting word are held for software while any status bit is set.

Top module: `ibuf_ecc_top`

## Requirements
- R1: After synchronous reset, both status bits, `irq`, `rd_valid`, `cap_iid` and `cap_wid` are 0.
- R2: A read issued with `rd_en` in cycle N presents `rd_valid`=1 and the stored word on `rd_data` in cycle N+1. A cleanly written word reads back unchanged, with `rd_sbe`=0 and `rd_dbe`=0.
- R3: A word written with protection on and `inj_mode` 2'b01 or 2'b10 has data bit 0 inverted in storage. Reading it with protection on returns the original word, with `rd_sbe`=1 and `rd_dbe`=0, and sets `sts[0]`.
- R4: A word written with protection on and `inj_mode` 2'b11 has data bits 0 and 1 inverted in storage. Reading it with protection on returns the stored (corrupted) word, with `rd_dbe`=1 and `rd_sbe`=0, and sets `sts[1]`.
- R5: While `ecc_en`=0, a read returns the raw stored data, raises neither flag and leaves `sts` unchanged. A write made while `ecc_en`=0 stores all-zero check bits.
- R6: Status bits are sticky. A 1 in `sts_clr[i]` clears `sts[i]`, and a 0 in `sts_clr` leaves it unchanged. A new error in the same cycle as its bit's clear leaves the bit set.
- R7: `irq` is 1 exactly when some `sts[i]` and `int_en[i]` are both 1.
- R8: The first error seen while both status bits are clear loads `cap_iid`/`cap_wid` with the faulting entry's indices. Later errors do not change them while any status bit stays set.
- R9: Capture rearms once no status bit survives the current cycle's clear. If an error coincides with the clear of the last set bit, that error's indices are captured.
- R10: `inj_mode` has no effect on reads. It alters only the word written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Enables check-bit generation on write and checking on read |
| inj_mode | input | 2 | Fault control: 00 none, 01/10 flip data bit 0, 11 flip data bits 0 and 1 |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write entry |
| wr_data | input | 64 | Instruction word to store |
| wr_iid | input | 32 | Instruction index tag |
| wr_wid | input | 3 | Word index tag |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read entry |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_en` |
| rd_data | output | 64 | Read word, corrected when possible |
| rd_sbe | output | 1 | Corrected single-bit error on this read |
| rd_dbe | output | 1 | Uncorrectable double-bit error on this read |
| int_en | input | 2 | Interrupt enables, bit 0 single-bit, bit 1 double-bit |
| sts_clr | input | 2 | Write-1-to-clear strobes for `sts` |
| sts | output | 2 | Sticky status, bit 0 single-bit, bit 1 double-bit |
| irq | output | 1 | Interrupt request |
| cap_iid | output | 32 | Instruction index of the first captured error |
| cap_wid | output | 3 | Word index of the first captured error |

## Verification
The clear of a status bit and the detection of a new error can occur in the same clock. The bench provokes this case in two ways. It pulses `sts_clr` on the cycle that a corrupted entry is read, both for the bit the read sets and for the last remaining set bit. For each case the bench then judges two things: whether the bit survives, and whether the capture registers take the new indices or keep the old ones. A reference model that decides set-over-clear and rearm on its own supplies the expected values, and the bench compares them on every clock.

// File: rtl/ibuf_ecc_pkg.sv
package ibuf_ecc_pkg;

    localparam int DATA_W = 64;
    localparam int HAM_W  = 7;
    localparam int CHK_W  = HAM_W + 1;
    localparam int IID_W  = 32;
    localparam int WID_W  = 3;
    localparam int CODE_N = DATA_W + HAM_W;   // Hamming positions 1..CODE_N

    typedef enum logic [1:0] {
        INJ_NONE  = 2'b00,
        INJ_ONE_A = 2'b01,
        INJ_ONE_B = 2'b10,
        INJ_TWO   = 2'b11
    } inj_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  chk;
        logic [IID_W-1:0]  iid;
        logic [WID_W-1:0]  wid;
    } ib_entry_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sbe;
        logic              dbe;
    } ib_result_t;

    // Check bits: {overall parity, Hamming parity[6:0]}; data occupies non-power-of-two positions.
    function automatic logic [CHK_W-1:0] ecc_gen(logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] hp;
        int k;
        hp = '0;
        k  = 0;
        for (int p = 1; p <= CODE_N; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[k]) hp = hp ^ HAM_W'(p);
                k++;
            end
        end
        return {(^d) ^ (^hp), hp};
    endfunction

    // Invert the data bit that sits at Hamming position syn, if any.
    function automatic logic [DATA_W-1:0] ecc_fix(logic [DATA_W-1:0] d, logic [HAM_W-1:0] syn);
        logic [DATA_W-1:0] r;
        int k;
        r = d;
        k = 0;
        for (int p = 1; p <= CODE_N; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (syn == HAM_W'(p)) r[k] = ~r[k];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] inj_mask(inj_mode_e m);
        logic [DATA_W-1:0] r;
        r = '0;
        case (m)
            INJ_ONE_A, INJ_ONE_B: r[0] = 1'b1;
            INJ_TWO:              r[1:0] = 2'b11;
            default:              r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ibuf_ecc_store.sv
module ibuf_ecc_store
    import ibuf_ecc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 ecc_en,
    input  logic [1:0]           inj_mode,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [IID_W-1:0]     wr_iid,
    input  logic [WID_W-1:0]     wr_wid,
    input  logic [AW-1:0]        rd_addr,
    output ib_entry_t            rd_entry
);
    ib_entry_t mem [DEPTH];
    ib_entry_t wr_entry;

    always_comb begin
        wr_entry.chk  = ecc_en ? ecc_gen(wr_data) : '0;
        wr_entry.data = wr_data ^ inj_mask(inj_mode_e'(inj_mode));
        wr_entry.iid  = wr_iid;
        wr_entry.wid  = wr_wid;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_entry;
    end

    assign rd_entry = mem[rd_addr];
endmodule

// File: rtl/ibuf_ecc_check.sv
module ibuf_ecc_check
    import ibuf_ecc_pkg::*;
(
    input  logic              ecc_en,
    input  logic [DATA_W-1:0] data,
    input  logic [CHK_W-1:0]  chk,
    output ib_result_t        res
);
    logic [CHK_W-1:0] regen;
    logic [HAM_W-1:0] syn;
    logic             par_err;

    always_comb begin
        regen   = ecc_gen(data);
        syn     = regen[HAM_W-1:0] ^ chk[HAM_W-1:0];
        par_err = ^{data, chk};
        res     = '{data: data, sbe: 1'b0, dbe: 1'b0};
        if (ecc_en) begin
            if (par_err) begin
                res.sbe  = 1'b1;
                res.data = ecc_fix(data, syn);
            end else if (syn != '0) begin
                res.dbe  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ibuf_ecc_status.sv
module ibuf_ecc_status
    import ibuf_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_sbe,
    input  logic             ev_dbe,
    input  logic [IID_W-1:0] ev_iid,
    input  logic [WID_W-1:0] ev_wid,
    input  logic [1:0]       clr,
    input  logic [1:0]       int_en,
    output logic [1:0]       sts,
    output logic             irq,
    output logic [IID_W-1:0] cap_iid,
    output logic [WID_W-1:0] cap_wid
);
    logic [1:0] kept;
    logic [1:0] ev;

    assign kept = sts & ~clr;
    assign ev   = {ev_dbe, ev_sbe};

    always_ff @(posedge clk) begin
        if (rst) begin
            sts     <= '0;
            cap_iid <= '0;
            cap_wid <= '0;
        end else begin
            sts <= kept | ev;
            if (kept == '0 && ev != '0) begin
                cap_iid <= ev_iid;
                cap_wid <= ev_wid;
            end
        end
    end

    assign irq = |(sts & int_en);
endmodule

// File: rtl/ibuf_ecc_top.sv
module ibuf_ecc_top
    import ibuf_ecc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ecc_en,
    input  logic [1:0]        inj_mode,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [63:0]       wr_data,
    input  logic [31:0]       wr_iid,
    input  logic [2:0]        wr_wid,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic              rd_sbe,
    output logic              rd_dbe,
    input  logic [1:0]        int_en,
    input  logic [1:0]        sts_clr,
    output logic [1:0]        sts,
    output logic              irq,
    output logic [31:0]       cap_iid,
    output logic [2:0]        cap_wid
);
    ib_entry_t  entry;
    ib_result_t res;

    ibuf_ecc_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .ecc_en   (ecc_en),
        .inj_mode (inj_mode),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_iid   (wr_iid),
        .wr_wid   (wr_wid),
        .rd_addr  (rd_addr),
        .rd_entry (entry)
    );

    ibuf_ecc_check u_check (
        .ecc_en (ecc_en),
        .data   (entry.data),
        .chk    (entry.chk),
        .res    (res)
    );

    ibuf_ecc_status u_status (
        .clk     (clk),
        .rst     (rst),
        .ev_sbe  (rd_en & res.sbe),
        .ev_dbe  (rd_en & res.dbe),
        .ev_iid  (entry.iid),
        .ev_wid  (entry.wid),
        .clr     (sts_clr),
        .int_en  (int_en),
        .sts     (sts),
        .irq     (irq),
        .cap_iid (cap_iid),
        .cap_wid (cap_wid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_sbe   <= 1'b0;
            rd_dbe   <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= res.data;
                rd_sbe  <= res.sbe;
                rd_dbe  <= res.dbe;
            end else begin
                rd_sbe  <= 1'b0;
                rd_dbe  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ibuf_ecc_sva.sv
module ibuf_ecc_sva (
    input logic        clk,
    input logic        rst,
    input logic        ecc_en,
    input logic        rd_en,
    input logic        rd_valid,
    input logic        rd_sbe,
    input logic        rd_dbe,
    input logic [1:0]  sts,
    input logic [1:0]  sts_clr,
    input logic [31:0] cap_iid
);
    a_r2_valid_follows_read: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rd_sbe && rd_dbe));

    a_r3_sbe_sets_status: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_sbe) |-> sts[0]);

    a_r4_dbe_sets_status: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_dbe) |-> sts[1]);

    a_r5_off_no_flags: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !ecc_en) |=> (!rd_sbe && !rd_dbe));

    a_r6_sticky_single: assert property (@(posedge clk) disable iff (rst)
        (sts[0] && !sts_clr[0]) |=> sts[0]);

    a_r6_sticky_double: assert property (@(posedge clk) disable iff (rst)
        (sts[1] && !sts_clr[1]) |=> sts[1]);

    a_r8_capture_held: assert property (@(posedge clk) disable iff (rst)
        ((sts & ~sts_clr) != 2'b00) |=> $stable(cap_iid));
endmodule

bind ibuf_ecc_top ibuf_ecc_sva u_sva (
    .clk      (clk),
    .rst      (rst),
    .ecc_en   (ecc_en),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .rd_sbe   (rd_sbe),
    .rd_dbe   (rd_dbe),
    .sts      (sts),
    .sts_clr  (sts_clr),
    .cap_iid  (cap_iid)
);

// File: tb/ibuf_ecc_top_test.sv
`timescale 1ns/1ps
module ibuf_ecc_top_test;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ecc_en = 1'b1;
    logic [1:0] inj_mode = 2'b00;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [31:0] wr_iid = '0;
    logic [2:0] wr_wid = '0;
    logic rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [1:0] int_en = 2'b00;
    logic [1:0] sts_clr = 2'b00;
    logic rd_valid, rd_sbe, rd_dbe, irq;
    logic [63:0] rd_data;
    logic [1:0] sts;
    logic [31:0] cap_iid;
    logic [2:0] cap_wid;

    int tests = 0;
    int fails = 0;
    bit cmp_on = 0;
    string cur_req = "R2";

    always #2.5 clk = ~clk;

    ibuf_ecc_top #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .ecc_en(ecc_en), .inj_mode(inj_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_iid(wr_iid), .wr_wid(wr_wid),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_sbe(rd_sbe), .rd_dbe(rd_dbe), .int_en(int_en), .sts_clr(sts_clr),
        .sts(sts), .irq(irq), .cap_iid(cap_iid), .cap_wid(cap_wid)
    );

    // Reference model state
    logic [63:0] m_orig   [DEPTH];
    logic [63:0] m_stored [DEPTH];
    int          m_flips  [DEPTH];
    logic [31:0] m_iid    [DEPTH];
    logic [2:0]  m_wid    [DEPTH];
    bit          e_valid, e_sbe, e_dbe;
    logic [63:0] e_data;
    logic [1:0]  e_sts;
    logic [31:0] e_cap_iid;
    logic [2:0]  e_cap_wid;

    always @(posedge clk) begin
        if (rst) begin
            e_valid = 0; e_sbe = 0; e_dbe = 0; e_data = '0;
            e_sts = 2'b00; e_cap_iid = '0; e_cap_wid = '0;
        end else begin
            bit ns, nd;
            logic [1:0] kept;
            ns = 0; nd = 0;
            e_valid = rd_en;
            if (rd_en) begin
                e_data = m_stored[rd_addr];
                if (ecc_en && m_flips[rd_addr] == 1) begin
                    ns = 1; e_data = m_orig[rd_addr];
                end else if (ecc_en && m_flips[rd_addr] == 2) begin
                    nd = 1;
                end
            end
            e_sbe = ns; e_dbe = nd;
            kept = e_sts & ~sts_clr;
            if (kept == 2'b00 && (ns || nd)) begin
                e_cap_iid = m_iid[rd_addr];
                e_cap_wid = m_wid[rd_addr];
            end
            e_sts = kept | {nd, ns};
            if (wr_en) begin
                m_orig[wr_addr]   = wr_data;
                m_flips[wr_addr]  = (inj_mode == 2'b00) ? 0 : (inj_mode == 2'b11) ? 2 : 1;
                m_stored[wr_addr] = wr_data ^ ((inj_mode == 2'b00) ? 64'd0 :
                                               (inj_mode == 2'b11) ? 64'd3 : 64'd1);
                m_iid[wr_addr]    = wr_iid;
                m_wid[wr_addr]    = wr_wid;
            end
        end
    end

    task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R2", "rd_valid", 64'(rd_valid), 64'(e_valid));
            if (e_valid) begin
                check(cur_req, "rd_data", rd_data, e_data);
                check("R3", "rd_sbe", 64'(rd_sbe), 64'(e_sbe));
                check("R4", "rd_dbe", 64'(rd_dbe), 64'(e_dbe));
            end
            check("R6", "sts", 64'(sts), 64'(e_sts));
            check("R7", "irq", 64'(irq), 64'(|(e_sts & int_en)));
            if (e_sts != 2'b00) begin
                check("R8", "cap_iid", 64'(cap_iid), 64'(e_cap_iid));
                check("R8", "cap_wid", 64'(cap_wid), 64'(e_cap_wid));
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        wr_en = 0; rd_en = 0; sts_clr = 2'b00;
    endtask

    task automatic wr(int a, logic [63:0] d, logic [31:0] iid, logic [2:0] wid, logic [1:0] inj);
        wr_en = 1; wr_addr = AW'(a); wr_data = d; wr_iid = iid; wr_wid = wid; inj_mode = inj;
        tick();
        inj_mode = 2'b00;
    endtask

    task automatic rd(int a);
        rd_en = 1; rd_addr = AW'(a);
        tick();
    endtask

    initial begin
        #(5.0 * 20000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        // R1: reset state
        check("R1", "sts", 64'(sts), 64'd0);
        check("R1", "irq", 64'(irq), 64'd0);
        check("R1", "rd_valid", 64'(rd_valid), 64'd0);
        check("R1", "cap_iid", 64'(cap_iid), 64'd0);
        check("R1", "cap_wid", 64'(cap_wid), 64'd0);
        cmp_on = 1;
        int_en = 2'b11;

        // R2: clean traffic with varied patterns
        cur_req = "R2";
        for (int i = 0; i < 8; i++)
            wr(i, {32'hA5A50000 + 32'(i), ~(32'h1 << i)}, 32'h100 + 32'(i), 3'(i), 2'b00);
        wr(12, 64'hFFFF_FFFF_FFFF_FFFF, 32'hDEAD_BEEF, 3'd7, 2'b00);
        wr(13, 64'h0, 32'h0, 3'd0, 2'b00);
        for (int i = 0; i < 8; i++) rd(i);
        rd(12); rd(13);

        // R3: single-bit faults corrected, first capture held (R8)
        cur_req = "R3";
        wr(8, 64'h0123_4567_89AB_CDEF, 32'hCAFE_0008, 3'd5, 2'b01);
        wr(9, 64'hFEDC_BA98_7654_3210, 32'hCAFE_0009, 3'd2, 2'b10);
        rd(8);
        check("R3", "corrected data", rd_data, 64'h0123_4567_89AB_CDEF);
        rd(9);
        check("R8", "cap_iid kept", 64'(cap_iid), 64'hCAFE_0008);

        // R10: injection control during a read changes nothing
        cur_req = "R10";
        inj_mode = 2'b11;
        rd(8);
        inj_mode = 2'b00;
        check("R10", "read with inj set", rd_data, 64'h0123_4567_89AB_CDEF);
        check("R10", "rd_dbe", 64'(rd_dbe), 64'd0);

        // R4: double-bit fault detected, returned uncorrected
        cur_req = "R4";
        wr(10, 64'h5555_AAAA_5555_AAAC, 32'hCAFE_000A, 3'd3, 2'b11);
        rd(10);
        check("R4", "uncorrected data", rd_data, 64'h5555_AAAA_5555_AAAF);

        // R6/R7: write-1-to-clear and enable gating
        cur_req = "R6";
        sts_clr = 2'b00; tick();
        check("R6", "zero clear no effect", 64'(sts), 64'd3);
        sts_clr = 2'b01; tick();
        check("R6", "clear single", 64'(sts), 64'd2);
        int_en = 2'b01; tick();
        check("R7", "irq masked", 64'(irq), 64'd0);
        int_en = 2'b10; tick();
        check("R7", "irq enabled", 64'(irq), 64'd1);
        sts_clr = 2'b10; tick();
        check("R6", "all clear", 64'(sts), 64'd0);
        int_en = 2'b11;

        // R9: rearm, and clear coinciding with a new error
        cur_req = "R9";
        rd(10);
        check("R9", "rearmed capture", 64'(cap_iid), 64'hCAFE_000A);
        sts_clr = 2'b10; rd(8);
        check("R9", "capture on clear+error", 64'(cap_iid), 64'hCAFE_0008);
        check("R9", "status after clear+error", 64'(sts), 64'd1);
        sts_clr = 2'b01; rd(9);
        check("R6", "set wins over clear", 64'(sts), 64'd1);
        check("R9", "captured again", 64'(cap_iid), 64'hCAFE_0009);
        sts_clr = 2'b01; tick();

        // R5: protection off
        cur_req = "R5";
        ecc_en = 0;
        wr(11, 64'h1111_2222_3333_4444, 32'hCAFE_000B, 3'd1, 2'b01);
        rd(11);
        check("R5", "raw data", rd_data, 64'h1111_2222_3333_4445);
        rd(8);
        check("R5", "no flag", 64'(rd_sbe), 64'd0);
        check("R5", "status unchanged", 64'(sts), 64'd0);
        ecc_en = 1;
        cur_req = "R2";
        rd(0);

        // R1: reset mid-run
        rd(10);
        rst = 1; cmp_on = 0; tick();
        check("R1", "sts after reset", 64'(sts), 64'd0);
        check("R1", "irq after reset", 64'(irq), 64'd0);
        rst = 0;
        tick();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule